// File: doc/BRIEF.md
# Multi-function bidirectional GPIO port

This block is an 8-bit general-purpose I/O port in which every pin is configured on its own. Each pin can be a driven digital output, a sampled digital input, an analog input whose digital buffer is gated off, or a wakeup source for the stop-mode logic. Two per-bit control registers choose the use of each pin. The direction register decides whether the pin drives. The kind register decides, for pins that do not drive, whether the pin is digital or analog. A third register holds the output latches. A chip-level stop-wake enable input opens the wakeup path on every pin that is not an output.

The bus side is a plain register port. A one-cycle write strobe carries an address and write data, and the read data is a combinational function of the address. There is no back-pressure: a write is taken on every clock edge where the strobe is high, so back-to-back writes in consecutive cycles all take effect.

The pin side gives an output enable and an output value for each pad and takes the pad level in. It also drives per-bit analog-select and wakeup-enable outputs, plus a wakeup level that has been synchronised and gated, for the converter and stop-mode logic outside this block.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the direction register reads 0x00, the kind register reads 0xFF and the output latches hold 0x00. `pad_oe`, `pad_out` and `ana_sel` are all zero, so every pin is a digital input.
- R2: A pin whose direction bit is 1 has `pad_oe` high. A pin whose direction bit is 0 has `pad_oe` low. The new value shows on the clock edge that takes the write.
- R3: For a pin with direction 0 and kind 1, a data-register read returns the pad level through a two-stage synchroniser. A pad change is seen on the second rising edge after it, and not on the first.
- R4: For a pin with direction 0 and kind 0, `ana_sel` is 1, the data-register read returns 0 and `wake_lvl` is 0.
- R5: `wake_en` for each bit is 1 exactly when its direction bit is 0 and `stop_wake_en` is 1. `wake_lvl` is the synchronised pad level of a digital-input pin ANDed with its `wake_en`.
- R6: For a pin in output mode, a data-register read returns the output latch and not the pad level.
- R7: A write to the data register updates every latch bit, whatever the pin mode. `pad_out` shows the latch only on output pins and is 0 elsewhere. A latch written while its pin was an input appears once the pin is switched to output.
- R8: The modes of the pins are independent. Any mix of output, digital-input and analog pins gives, for each bit, the result set by that bit's own control bits.
- R9: Address 0 is the data register, address 1 is the direction register (1 = output) and address 2 is the kind register (1 = digital, 0 = analog). Reads return that register's contents. Address 3 reads 0, and writes to address 3 change nothing.
- R10: Writes on consecutive cycles are all accepted with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| stop_wake_en | input | 1 | Enables wakeup on all non-output pins |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Per-pin output enable (0 = high impedance) |
| pad_out | output | 8 | Per-pin output value |
| ana_sel | output | 8 | Per-pin analog-input select |
| wake_en | output | 8 | Per-pin wakeup enable |
| wake_lvl | output | 8 | Synchronised, gated pad level for wakeup detection |

## Verification
Register writes take effect at the rising edge that samples the strobe. `pad_oe`, `pad_out`, `ana_sel` and `wake_en` therefore change one edge after the write, and register reads are combinational. Pad levels pass through two flops, so the pad-derived read bits and `wake_lvl` settle on the second edge after a pad or mode change.

Inputs are driven at the falling edge. The bench samples one falling edge after each write and, in the exhaustive configuration sweep, waits two further edges after the last write before comparing pad-derived values. A dedicated test samples after the first and after the second edge to pin down the synchroniser depth exactly.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_LATCH = 2'd0,
    REG_DIR   = 2'd1,
    REG_KIND  = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    USE_DIG_IN = 2'd0,
    USE_OUT    = 2'd1,
    USE_ANA    = 2'd2
  } pin_use_e;

  // Direction dominates; kind only matters for non-driven pins.
  function automatic pin_use_e decode_use(input logic dir_bit, input logic kind_bit);
    if (dir_bit)       return USE_OUT;
    else if (kind_bit) return USE_DIG_IN;
    else               return USE_ANA;
  endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mux_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      kind_q,
  output logic [W-1:0]      latch_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      kind_q  <= '1;
      latch_q <= '0;
    end else if (we) begin
      unique case (reg_sel_e'(addr))
        REG_LATCH: latch_q <= wdata;
        REG_DIR:   dir_q   <= wdata;
        REG_KIND:  kind_q  <= wdata;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
  import gpio_mux_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] kind_q,
  input  logic         stop_wake,
  output logic [W-1:0] oe,
  output logic [W-1:0] ana,
  output logic [W-1:0] dig_in,
  output logic [W-1:0] wen
);

  for (genvar b = 0; b < W; b++) begin : g_pin
    pin_use_e use_b;
    always_comb begin
      use_b     = decode_use(dir_q[b], kind_q[b]);
      oe[b]     = (use_b == USE_OUT);
      ana[b]    = (use_b == USE_ANA);
      dig_in[b] = (use_b == USE_DIG_IN);
      wen[b]    = (use_b != USE_OUT) && stop_wake;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)       chain[s] <= '0;
      else if (s == 0)  chain[s] <= d;
      else              chain[s] <= chain[(s > 0) ? s-1 : 0];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              stop_wake_en,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      ana_sel,
  output logic [W-1:0]      wake_en,
  output logic [W-1:0]      wake_lvl
);

  logic [W-1:0] dir_q, kind_q, latch_q;
  logic [W-1:0] oe_w, ana_w, dig_w, wen_w;
  logic [W-1:0] pad_gated, pad_sync, data_view;

  gpio_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .dir_q   (dir_q),
    .kind_q  (kind_q),
    .latch_q (latch_q)
  );

  gpio_pin_decode #(.W(W)) u_dec (
    .dir_q     (dir_q),
    .kind_q    (kind_q),
    .stop_wake (stop_wake_en),
    .oe        (oe_w),
    .ana       (ana_w),
    .dig_in    (dig_w),
    .wen       (wen_w)
  );

  // The digital input buffer is shut off on analog pins.
  assign pad_gated = pad_in & ~ana_w;

  gpio_in_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_gated),
    .q     (pad_sync)
  );

  for (genvar b = 0; b < W; b++) begin : g_view
    always_comb begin
      if (oe_w[b])       data_view[b] = latch_q[b];
      else if (dig_w[b]) data_view[b] = pad_sync[b];
      else               data_view[b] = 1'b0;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      REG_LATCH: bus_rdata = data_view;
      REG_DIR:   bus_rdata = dir_q;
      REG_KIND:  bus_rdata = kind_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign pad_oe   = oe_w;
  assign pad_out  = latch_q & oe_w;
  assign ana_sel  = ana_w;
  assign wake_en  = wen_w;
  assign wake_lvl = pad_sync & dig_w & wen_w;

endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_we,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] ana_sel,
  input logic [W-1:0] wake_en,
  input logic [W-1:0] wake_lvl
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pad_oe == '0 && ana_sel == '0 && pad_out == '0));

  // R2
  dir_write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd1) |=> (pad_oe == $past(bus_wdata)));

  // R7
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd0) |=> ((pad_out & pad_oe) == ($past(bus_wdata) & pad_oe)));

  // R7
  out_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  // R4
  ana_not_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ana_sel & pad_oe) == '0);

  // R4
  ana_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> ((bus_rdata & ana_sel) == '0));

  // R6
  out_read_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> ((bus_rdata & pad_oe) == (pad_out & pad_oe)));

  // R5
  wake_off_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wake_en & pad_oe) == '0) && ((wake_lvl & ~wake_en) == '0));

  // R9
  spare_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0));

endmodule

bind gpio_mux_port gpio_mux_port_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .ana_sel   (ana_sel),
  .wake_en   (wake_en),
  .wake_lvl  (wake_lvl)
);

// File: tb/sim_gpio_mux_port.sv
`timescale 1ns/1ps
module sim_gpio_mux_port;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0;
  logic [1:0]   bus_addr = 2'd0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         stop_wake_en = 1'b0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_oe, pad_out, ana_sel, wake_en, wake_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpio_mux_port #(.W(W)) u0 (
    .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .stop_wake_en, .pad_in, .pad_oe, .pad_out, .ana_sel, .wake_en, .wake_lvl
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] v);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
    bus_addr = 2'd0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", pad_oe, 8'h00);
    check("R1 out", pad_out, 8'h00);
    check("R1 ana", ana_sel, 8'h00);
    rd(2'd1, v); check("R1 dir reg", v, 8'h00);
    rd(2'd2, v); check("R1 kind reg", v, 8'hFF);
    rd(2'd0, v); check("R1 data read", v, 8'h00);

    // R9 spare address ignored, reads zero
    wr(2'd3, 8'hFF);
    rd(2'd1, v); check("R9 dir after spare write", v, 8'h00);
    rd(2'd2, v); check("R9 kind after spare write", v, 8'hFF);
    check("R9 oe after spare write", pad_oe, 8'h00);
    rd(2'd3, v); check("R9 spare read", v, 8'h00);

    // R3 synchroniser depth: all digital inputs
    @(negedge clk); pad_in = 8'hA5;
    @(negedge clk); rd(2'd0, v); check("R3 one edge", v, 8'h00);
    @(negedge clk); rd(2'd0, v); check("R3 two edges", v, 8'hA5);

    // R10 back-to-back writes in consecutive cycles
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h0F;
    @(negedge clk); bus_addr = 2'd2; bus_wdata = 8'h33;
    @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'h96;
    @(negedge clk); bus_we = 1'b0;
    rd(2'd1, v); check("R10 dir", v, 8'h0F);
    rd(2'd2, v); check("R10 kind", v, 8'h33);
    check("R10 out", pad_out, 8'h06);

    // R7 latch hidden until output mode
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h3C);
    check("R7 hidden out", pad_out, 8'h00);
    check("R7 hidden oe", pad_oe, 8'h00);
    wr(2'd1, 8'hFF);
    check("R7 revealed out", pad_out, 8'h3C);

    // R6 read returns latch, not pad
    pad_in = 8'hC3;
    repeat (3) @(negedge clk);
    rd(2'd0, v); check("R6 latch over pad", v, 8'h3C);

    // R2 R4 R5 R7 R8 exhaustive sweep of direction with mixed kinds
    for (int d = 0; d < 256; d++) begin
      for (int k = 0; k < 4; k++) begin
        logic [W-1:0] dv, kv, lv, pv, we_exp;
        logic sw;
        dv = W'(d);
        kv = W'(d * 53 + k * 91 + 17);
        lv = W'(d ^ (k * 77 + 3));
        pv = W'(~d ^ (k * 45));
        sw = k[0];
        @(negedge clk);
        pad_in = pv; stop_wake_en = sw;
        wr(2'd1, dv);
        wr(2'd2, kv);
        wr(2'd0, lv);
        repeat (2) @(negedge clk);
        we_exp = ~dv & {W{sw}};
        check("R2 oe", pad_oe, dv);
        check("R7 out", pad_out, lv & dv);
        check("R4 ana", ana_sel, ~dv & ~kv);
        check("R5 wake_en", wake_en, we_exp);
        check("R5 wake_lvl", wake_lvl, pv & ~dv & kv & we_exp);
        rd(2'd0, v);
        check("R8 data read", v, (lv & dv) | (pv & ~dv & kv));
      end
    end

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule